// File: doc/BRIEF.md
# Overcurrent Hiccup-and-Latch Sequencer

This block is the digital protection sequencer for one switching-regulator phase. Every switching period it is told, by a one-clock strobe, that a cycle has ended. It also gets an overcurrent comparator flag, which counts only while a sample-enable marks the short valid window after the high-side switch turns off. From these it gates the raw high-side PWM request into a pair of gate-enable outputs.

When the first qualified fault arrives during normal operation, the block starts counting switching cycles. For the first eight cycles it drops the next PWM pulse whenever the cycle before it held a fault. During the following eight cycles it only watches. A fault in that second window turns both gate enables off and holds them off. A clean second window clears the count and restores normal gating.

The latched-off condition ends only when the asynchronous active-low reset is applied or the chip-enable is pulled low. When the latch is entered, a one-clock trip pulse and a level flag tell a supervisor about it.

Top module: `oc_hiccup_seq`

## Requirements
- R1: A fault is qualified only when `oc_flag` and `oc_sample_en` are both high in the same clock. An `oc_flag` without `oc_sample_en` changes neither state nor gating.
- R2: The `mode` encoding is 0 normal, 1 skip, 2 watch, 3 latched. A qualified fault in normal mode moves `mode` to 1 at the next clock edge and starts the cycle count at zero.
- R3: In skip mode the high-side pulse right after entry is suppressed. After each `sw_strobe`, the next pulse is suppressed if the cycle that just ended held a qualified fault, and passes otherwise. A fault inside the current cycle does not cut the pulse already in progress.
- R4: The 8th `sw_strobe` after entry moves skip to watch. A qualified fault in watch moves `mode` to 3 at the next clock edge.
- R5: If watch sees no qualified fault before its 8th `sw_strobe` (the 16th since entry), `mode` returns to 0 at that strobe. A qualified fault during skip never latches.
- R6: In latched mode `upper_en` and `lower_en` are both 0. Further faults and strobes have no effect, and the mode stays 3 until `rst_n` goes low or `chip_en` goes low.
- R7: `trip` is high for exactly the one clock after the latch is entered. `latched` is high for as long as `mode` is 3.
- R8: In normal and watch mode, and in skip mode when the pulse is not suppressed, `upper_en` equals `pwm_req` and `lower_en` equals its complement, both without delay. While `rst_n` or `chip_en` is low, both enables are 0.
- R9: `chip_en` low returns `mode` to 0 at the next clock edge, so normal gating resumes as soon as it goes high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Converter enable; low clears the sequencer and blanks the gates |
| sw_strobe | input | 1 | One-clock pulse that marks the end of a switching cycle |
| oc_flag | input | 1 | Overcurrent comparator output |
| oc_sample_en | input | 1 | High during the valid sensing window after high-side turn-off |
| pwm_req | input | 1 | Raw high-side PWM request |
| upper_en | output | 1 | Gated high-side enable |
| lower_en | output | 1 | Gated low-side enable |
| trip | output | 1 | One-clock pulse when the latch is entered |
| latched | output | 1 | Level flag for the latched-off state |
| mode | output | 2 | Sequencer state: 0 normal, 1 skip, 2 watch, 3 latched |

## Verification
The bench drives faults in three ways.

- A flag with no sample-enable tests that only qualified faults count.
- A fault in one skip cycle followed by a clean cycle tests whether a pulse is suppressed for a fault in the cycle before it and not for a fault in the cycle now running.
- Runs of exactly seven and eight strobes show where the two eight-cycle window edges fall.

A clean watch window and a faulted watch window separate recovery from latch-off. Once the latch is set, faults and strobes are applied again, and the latch is then released by chip-enable and, in a separate run, by reset, to show that only those two inputs end it.

// File: rtl/oc_seq_pkg.sv
package oc_seq_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_SKIP    = 2'd1,
        ST_WATCH   = 2'd2,
        ST_LATCHED = 2'd3
    } oc_state_e;

    typedef struct packed {
        oc_state_e state;
        logic      skip;
        logic      trip;
    } seq_regs_t;

endpackage

// File: rtl/oc_fault_qual.sv
module oc_fault_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    input  logic oc_sample_en,
    input  logic clear,
    output logic fault_now,
    output logic fault_cycle
);

    logic seen_d, seen_q;

    always_comb begin
        fault_now = oc_flag & oc_sample_en;
        if (clear) begin
            seen_d = 1'b0;
        end else begin
            seen_d = seen_q | fault_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= seen_d;
        end
    end

    assign fault_cycle = seen_q | fault_now;

    AST_NO_SAMPLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !oc_sample_en |-> !fault_now); // R1

endmodule

// File: rtl/oc_window_ctr.sv
module oc_window_ctr #(
    parameter int WIN_CYCLES = 8,
    parameter int CNT_W      = $clog2(2 * WIN_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic skip_last,
    output logic watch_last
);

    localparam logic [CNT_W-1:0] SKIP_END  = CNT_W'(WIN_CYCLES - 1);
    localparam logic [CNT_W-1:0] WATCH_END = CNT_W'(2 * WIN_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(2 * WIN_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign skip_last  = (cnt_q == SKIP_END);
    assign watch_last = (cnt_q == WATCH_END);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX); // R4

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0); // R5

endmodule

// File: rtl/oc_gate_mux.sv
module oc_gate_mux
    import oc_seq_pkg::*;
(
    input  logic      rst_n,
    input  logic      chip_en,
    input  logic      pwm_req,
    input  oc_state_e state,
    input  logic      skip,
    output logic      upper_en,
    output logic      lower_en
);

    logic run_ok;
    logic pass_hi;

    always_comb begin
        run_ok  = rst_n & chip_en;
        pass_hi = pwm_req;
        if (state == ST_SKIP && skip) begin
            pass_hi = 1'b0;
        end
        if (!run_ok || state == ST_LATCHED) begin
            upper_en = 1'b0;
            lower_en = 1'b0;
        end else begin
            upper_en = pass_hi;
            lower_en = ~pass_hi;
        end
    end

endmodule

// File: rtl/oc_hiccup_seq.sv
module oc_hiccup_seq
    import oc_seq_pkg::*;
#(
    parameter int WIN_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_en,
    input  logic       sw_strobe,
    input  logic       oc_flag,
    input  logic       oc_sample_en,
    input  logic       pwm_req,
    output logic       upper_en,
    output logic       lower_en,
    output logic       trip,
    output logic       latched,
    output logic [1:0] mode
);

    localparam int CNT_W = $clog2(2 * WIN_CYCLES + 1);

    seq_regs_t r_d, r_q;

    logic fault_now, fault_cycle;
    logic qual_clr;
    logic ctr_clr, ctr_inc;
    logic skip_last, watch_last;

    oc_fault_qual u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .oc_flag      (oc_flag),
        .oc_sample_en (oc_sample_en),
        .clear        (qual_clr),
        .fault_now    (fault_now),
        .fault_cycle  (fault_cycle)
    );

    oc_window_ctr #(
        .WIN_CYCLES (WIN_CYCLES),
        .CNT_W      (CNT_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (ctr_clr),
        .inc        (ctr_inc),
        .skip_last  (skip_last),
        .watch_last (watch_last)
    );

    oc_gate_mux u_gate (
        .rst_n    (rst_n),
        .chip_en  (chip_en),
        .pwm_req  (pwm_req),
        .state    (r_q.state),
        .skip     (r_q.skip),
        .upper_en (upper_en),
        .lower_en (lower_en)
    );

    always_comb begin
        r_d      = r_q;
        r_d.trip = 1'b0;
        qual_clr = sw_strobe;
        ctr_clr  = 1'b0;
        ctr_inc  = 1'b0;

        if (!chip_en) begin
            r_d.state = ST_NORMAL;
            r_d.skip  = 1'b0;
            ctr_clr   = 1'b1;
            qual_clr  = 1'b1;
        end else begin
            unique case (r_q.state)
                ST_NORMAL: begin
                    ctr_clr = 1'b1;
                    if (fault_now) begin
                        r_d.state = ST_SKIP;
                        r_d.skip  = 1'b1;
                        qual_clr  = 1'b1;
                    end
                end
                ST_SKIP: begin
                    if (sw_strobe) begin
                        ctr_inc  = 1'b1;
                        r_d.skip = fault_cycle;
                        if (skip_last) begin
                            r_d.state = ST_WATCH;
                            r_d.skip  = 1'b0;
                        end
                    end
                end
                ST_WATCH: begin
                    if (fault_now) begin
                        r_d.state = ST_LATCHED;
                        r_d.trip  = 1'b1;
                        ctr_clr   = 1'b1;
                    end else if (sw_strobe) begin
                        if (watch_last) begin
                            r_d.state = ST_NORMAL;
                            ctr_clr   = 1'b1;
                        end else begin
                            ctr_inc = 1'b1;
                        end
                    end
                end
                ST_LATCHED: begin
                    ctr_clr  = 1'b1;
                    r_d.skip = 1'b0;
                end
                default: begin
                    r_d.state = ST_NORMAL;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_NORMAL, skip: 1'b0, trip: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign trip    = r_q.trip;
    assign latched = (r_q.state == ST_LATCHED);
    assign mode    = r_q.state;

    always_comb begin
        if (!rst_n) begin
            AST_RESET_GATES_LOW: assert (!upper_en && !lower_en); // R8
        end
    end

    AST_ENTRY_TO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_NORMAL && chip_en && oc_flag && oc_sample_en)
        |=> r_q.state == ST_SKIP); // R2

    AST_SKIP_BLOCKS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SKIP && r_q.skip) |-> !upper_en); // R3

    AST_WATCH_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WATCH && chip_en && oc_flag && oc_sample_en)
        |=> r_q.state == ST_LATCHED); // R4

    AST_LATCH_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        latched |-> (!upper_en && !lower_en)); // R6

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && chip_en) |=> latched); // R6

    AST_TRIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> !trip); // R7

    AST_TRIP_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> trip); // R7

    AST_NORMAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_NORMAL && chip_en) |-> (upper_en == pwm_req && lower_en == !pwm_req)); // R8

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> r_q.state == ST_NORMAL); // R9

endmodule

// File: tb/tb_oc_hiccup_seq.sv
module tb_oc_hiccup_seq;

    logic       clk = 1'b0;
    logic       rst_n, chip_en, sw_strobe, oc_flag, oc_sample_en, pwm_req;
    logic       upper_en, lower_en, trip, latched;
    logic [1:0] mode;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    oc_hiccup_seq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_en      (chip_en),
        .sw_strobe    (sw_strobe),
        .oc_flag      (oc_flag),
        .oc_sample_en (oc_sample_en),
        .pwm_req      (pwm_req),
        .upper_en     (upper_en),
        .lower_en     (lower_en),
        .trip         (trip),
        .latched      (latched),
        .mode         (mode)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic o, input logic e, input logic p);
        @(negedge clk);
        sw_strobe    = s;
        oc_flag      = o;
        oc_sample_en = e;
        pwm_req      = p;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; chip_en = 1'b1; pwm_req = 1'b1;
        sw_strobe = 1'b0; oc_flag = 1'b0; oc_sample_en = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R8 reset upper", int'(upper_en), 0);
        chk("R8 reset lower", int'(lower_en), 0);
        chk("R2 reset mode", int'(mode), 0);
        chk("R7 reset trip", int'(trip), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_normal;
        cyc(0, 0, 0, 1);
        chk("R8 normal upper hi", int'(upper_en), 1);
        chk("R8 normal lower lo", int'(lower_en), 0);
        cyc(0, 0, 0, 0);
        chk("R8 normal upper lo", int'(upper_en), 0);
        chk("R8 normal lower hi", int'(lower_en), 1);
        cyc(0, 1, 0, 1);
        cyc(1, 1, 0, 1);
        chk("R1 unqualified flag mode", int'(mode), 0);
        chk("R1 unqualified flag upper", int'(upper_en), 1);
    endtask

    task automatic t_recover;
        cyc(0, 1, 1, 1);
        chk("R2 entry mode", int'(mode), 1);
        chk("R3 entry pulse skipped", int'(upper_en), 0);
        chk("R3 entry lower", int'(lower_en), 1);
        cyc(1, 0, 0, 1);
        chk("R3 clean cycle passes", int'(upper_en), 1);
        cyc(0, 1, 1, 1);
        chk("R3 current pulse kept", int'(upper_en), 1);
        chk("R5 skip fault no latch", int'(mode), 1);
        cyc(1, 0, 0, 1);
        chk("R3 faulted cycle skips next", int'(upper_en), 0);
        cyc(1, 0, 0, 1);
        chk("R3 pulse resumes", int'(upper_en), 1);
        for (int i = 4; i <= 7; i++) cyc(1, 0, 0, 1);
        chk("R4 seven strobes still skip", int'(mode), 1);
        cyc(1, 0, 0, 1);
        chk("R4 eighth strobe to watch", int'(mode), 2);
        chk("R8 watch follows pwm", int'(upper_en), 1);
        cyc(0, 1, 0, 0);
        chk("R1 unqualified in watch", int'(mode), 2);
        for (int i = 1; i <= 7; i++) cyc(1, 0, 0, 0);
        chk("R5 seven watch strobes", int'(mode), 2);
        cyc(1, 0, 0, 0);
        chk("R5 clean watch to normal", int'(mode), 0);
        chk("R8 back to normal lower", int'(lower_en), 1);
    endtask

    task automatic reach_latch;
        cyc(0, 1, 1, 0);
        for (int i = 1; i <= 8; i++) cyc(1, 0, 0, 0);
        chk("R4 watch reached", int'(mode), 2);
        cyc(0, 1, 1, 1);
        chk("R4 watch fault latches", int'(mode), 3);
        chk("R7 trip asserted", int'(trip), 1);
        chk("R7 latched level", int'(latched), 1);
        chk("R6 upper off", int'(upper_en), 0);
        chk("R6 lower off", int'(lower_en), 0);
    endtask

    task automatic t_latch_enable;
        reach_latch();
        cyc(0, 0, 0, 0);
        chk("R7 trip one clock", int'(trip), 0);
        chk("R6 lower off pwm low", int'(lower_en), 0);
        for (int i = 0; i < 20; i++) cyc(1, 1, 1, 1);
        chk("R6 faults ignored mode", int'(mode), 3);
        chk("R7 no retrip", int'(trip), 0);
        chk("R6 still upper off", int'(upper_en), 0);
        @(negedge clk);
        chip_en = 1'b0; sw_strobe = 1'b0; oc_flag = 1'b0; oc_sample_en = 1'b0; pwm_req = 1'b1;
        #1;
        chk("R8 disabled upper", int'(upper_en), 0);
        chk("R8 disabled lower", int'(lower_en), 0);
        @(posedge clk);
        #1;
        chk("R9 disable clears mode", int'(mode), 0);
        @(negedge clk);
        chip_en = 1'b1;
        #1;
        chk("R9 normal after enable", int'(upper_en), 1);
    endtask

    task automatic t_latch_reset;
        reach_latch();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R6 reset clears latch", int'(mode), 0);
        chk("R8 reset gates off", int'(upper_en), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0);
        chk("R6 normal after reset", int'(lower_en), 1);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_recover();
        t_latch_enable();
        t_latch_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule